// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets software drive a serial NOR flash one command at a time through three 32-bit registers. Software stores a command byte and a 24-bit flash address in the command register. It may place up to four bytes in the data word. It then writes the control word with a transmit byte count, a receive byte count and the start bit. The engine drives chip select low and shifts out one packed transmit stream: the command byte, the address bytes, then data bytes. It then clocks in the receive bytes, places them in the data word and releases chip select.

While a transfer runs, the control word reports busy and every register write is dropped. A transmit count of zero does nothing. Transmit counts above eight are treated as eight, and receive counts above four are treated as four. The serial clock rate comes from a two-bit divider field in the control word.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset the control word, the command register and the data word all read zero, chip select is high and the serial clock is low.
- R2: Register offsets are 0x00 control, 0x04 command, 0x08 data. Control fields read back as written: transmit count in bits 3:0, receive count in 7:4, a free size field in 18:17 and the clock divider in 25:24. The start bit 8 always reads 0. Reads show the value one cycle after the address is presented.
- R3: The transmit stream is the command byte (command bits 7:0), then address bits 31:24, 23:16 and 15:8 of the command register, then data word bits 7:0, 15:8, 23:16 and 31:24. Only the first N bytes of that stream go out, where N is the transmit count. Each byte goes out most significant bit first.
- R4: Receive bytes follow the transmit bytes. The first received byte lands in data bits 7:0 and the next in 15:8, and so on. Unreceived upper bytes read zero. A receive count of 0 leaves the data word unchanged.
- R5: The link runs in SPI mode 0. The serial clock idles low, the output line changes only while the clock is low, and the output line is held low during receive bytes.
- R6: Chip select falls once per transfer and stays low across exactly 8 x (transmit + receive) clock pulses.
- R7: Control bit 16 reads 1 from the cycle after an accepted start until the transfer completes, and reads 0 afterwards.
- R8: Any register write while busy is ignored, including a second start.
- R9: A start with a transmit count of 0 leaves chip select high, never sets busy and leaves the data word unchanged.
- R10: One serial clock half-period lasts 2^D system clock cycles, where D is the divider field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock to flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume that reset is held on the first clock edge. They also assume the register interface never presents X on the write strobe. The stimulus always waits for busy to clear before it expects a new start to be taken, except in the case where it deliberately writes during a transfer to test R8. The flash model changes its data line only on falling clock edges while chip select is low. This meets the mode 0 sampling the engine assumes.

// File: rtl/sfce_pkg.sv
`timescale 1ns/1ps
package sfce_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_BYTES = 3;
  localparam int RX_MAX     = WORD_W / 8;
  localparam int TX_MAX     = 1 + ADDR_BYTES + RX_MAX;
  localparam int CNT_W      = 4;
  localparam int SEL_W      = 2;
  localparam int SIZE_W     = 2;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_DATA = 4'h8;

  localparam int B_TX    = 0;
  localparam int B_RX    = 4;
  localparam int B_GO    = 8;
  localparam int B_BUSY  = 16;
  localparam int B_SIZE  = 17;
  localparam int B_DIV   = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} xfer_state_t;
endpackage

// File: rtl/sfce_sck_div.sv
`timescale 1ns/1ps
module sfce_sck_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int HC_W = ((1 << SEL_W) - 1) > 0 ? ((1 << SEL_W) - 1) : 1;

  logic [HC_W-1:0] cnt;
  logic [HC_W-1:0] half_m1;

  always_comb begin
    half_m1 = {HC_W{1'b1}} >> (HC_W - int'(sel));
    tick    = en && (cnt == half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfce_shifter.sv
`timescale 1ns/1ps
module sfce_shifter
  import sfce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CNT_W-1:0]  go_tx,
  input  logic [CNT_W-1:0]  go_rx,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] data_word,
  input  logic              tick,
  output logic              running,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int SR_W  = 8 * TX_MAX;
  localparam int BIT_W = $clog2(8 * (TX_MAX + RX_MAX) + 1);
  localparam int IDX_W = $clog2(RX_MAX);

  xfer_state_t       state;
  logic [SR_W-1:0]   tx_sh, load_v;
  logic [7:0]        rx_sh;
  logic [BIT_W-1:0]  bit_cnt, tx_bits, all_bits, bit_nxt;
  logic [IDX_W-1:0]  rx_idx;
  logic [CNT_W-1:0]  tx_eff, rx_eff;
  logic              in_rx;

  // command byte first, then address high to low
  assign load_v[SR_W-1 -: 8]  = cmd_word[7:0];
  genvar ab;
  generate
    for (ab = 0; ab < ADDR_BYTES; ab++) begin : g_addr
      assign load_v[SR_W-9-8*ab -: 8] = cmd_word[WORD_W-1-8*ab -: 8];
    end
    for (ab = 0; ab < RX_MAX; ab++) begin : g_data
      assign load_v[SR_W-9-8*ADDR_BYTES-8*ab -: 8] = data_word[8*ab +: 8];
    end
  endgenerate

  always_comb begin
    tx_eff  = (go_tx > CNT_W'(TX_MAX)) ? CNT_W'(TX_MAX) : go_tx;
    rx_eff  = (go_rx > CNT_W'(RX_MAX)) ? CNT_W'(RX_MAX) : go_rx;
    bit_nxt = bit_cnt + 1'b1;
    in_rx   = (bit_cnt >= tx_bits);
  end

  assign running = (state == ST_RUN);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_word  <= '0;
      bit_cnt  <= '0;
      tx_bits  <= '0;
      all_bits <= '0;
      rx_idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          tx_sh    <= load_v;
          mosi     <= load_v[SR_W-1];
          cs_n     <= 1'b0;
          sck      <= 1'b0;
          bit_cnt  <= '0;
          rx_idx   <= '0;
          rx_word  <= '0;
          tx_bits  <= BIT_W'(8 * tx_eff);
          all_bits <= BIT_W'(8 * (tx_eff + rx_eff));
          state    <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            if (in_rx) rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck     <= 1'b0;
            bit_cnt <= bit_nxt;
            tx_sh   <= tx_sh << 1;
            mosi    <= (bit_nxt < tx_bits) ? tx_sh[SR_W-2] : 1'b0;
            if (in_rx && bit_cnt[2:0] == 3'd7) begin
              rx_word[8*rx_idx +: 8] <= rx_sh;
              rx_idx <= rx_idx + 1'b1;
            end
            if (bit_nxt == all_bits) begin
              cs_n  <= 1'b1;
              mosi  <= 1'b0;
              state <= ST_DONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r6_select_held: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> !cs_n);
  a_r5_clock_idles_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  a_r5_data_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/sfce_regs.sv
`timescale 1ns/1ps
module sfce_regs
  import sfce_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              go,
  output logic [CNT_W-1:0]  go_tx,
  output logic [CNT_W-1:0]  go_rx,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] data_q,
  output logic [SEL_W-1:0]  div_q
);
  logic [CNT_W-1:0]  tx_q, rx_q;
  logic [SIZE_W-1:0] size_q;
  logic              wr_ok, wr_ctrl;

  always_comb begin
    wr_ok   = reg_wr && !busy;
    wr_ctrl = wr_ok && (reg_addr == OFS_CTRL);
    go      = wr_ctrl && reg_wdata[B_GO] && (reg_wdata[B_TX +: CNT_W] != '0);
    go_tx   = reg_wdata[B_TX +: CNT_W];
    go_rx   = reg_wdata[B_RX +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      size_q <= '0;
      div_q  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_q   <= reg_wdata[B_TX +: CNT_W];
        rx_q   <= reg_wdata[B_RX +: CNT_W];
        size_q <= reg_wdata[B_SIZE +: SIZE_W];
        div_q  <= reg_wdata[B_DIV +: SEL_W];
      end
      if (wr_ok && reg_addr == OFS_CMD)  cmd_q  <= reg_wdata;
      if (wr_ok && reg_addr == OFS_DATA) data_q <= reg_wdata;
      if (done && rx_q != '0)            data_q <= rx_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        OFS_CTRL: reg_rdata <= {6'b0, div_q, 5'b0, size_q, busy, 8'b0, rx_q, tx_q};
        OFS_CMD:  reg_rdata <= cmd_q;
        OFS_DATA: reg_rdata <= data_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  a_r8_locked_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr) |=> ($stable(cmd_q) && $stable(tx_q) && $stable(div_q)));
  a_r7_busy_after_go: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
  a_r9_zero_count_idle: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !busy && reg_addr == OFS_CTRL && reg_wdata[B_GO]
     && reg_wdata[B_TX +: CNT_W] == '0) |=> !busy);
endmodule

// File: rtl/sflash_cmd_engine.sv
`timescale 1ns/1ps
module sflash_cmd_engine
  import sfce_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic              go, busy, done, running, tick;
  logic [CNT_W-1:0]  go_tx, go_rx;
  logic [WORD_W-1:0] cmd_q, data_q, rx_word;
  logic [SEL_W-1:0]  div_q;

  sfce_regs u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .rx_word(rx_word), .go(go), .go_tx(go_tx), .go_rx(go_rx),
    .cmd_q(cmd_q), .data_q(data_q), .div_q(div_q)
  );

  sfce_sck_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .en(running), .sel(div_q), .tick(tick)
  );

  sfce_shifter u_shift (
    .clk(clk), .rst(rst), .go(go), .go_tx(go_tx), .go_rx(go_rx),
    .cmd_word(cmd_q), .data_word(data_q), .tick(tick), .running(running),
    .busy(busy), .done(done), .rx_word(rx_word), .sck(spi_sck),
    .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  a_r7_busy_covers_select: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);
endmodule

// File: tb/sflash_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sflash_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

  sflash_cmd_engine dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int drv_vec = 0, drv_bad = 0, mon_vec = 0, mon_bad = 0;
  logic [7:0] exp_q[$];
  string      cur_req = "R3";

  // flash model: response bits after the transmit phase
  logic [31:0] resp = '0;
  int          mtx_bits = 0;
  int          miso_idx = 0;
  always @(negedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) miso_idx <= 0;
    else          miso_idx <= miso_idx + 1;
  end
  assign spi_miso = (miso_idx >= mtx_bits && miso_idx < mtx_bits + 32)
                    ? resp[31 - (miso_idx - mtx_bits)] : 1'b0;

  // monitor: rebuild bytes on the output line and compare with the queue
  logic [7:0] mon_byte = '0;
  int         mon_bits = 0, sck_total = 0, cs_rise_total = 0;
  time        last_rise = 0, last_period = 0;
  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      logic [7:0] nb;
      nb = {mon_byte[6:0], spi_mosi};
      mon_byte = nb;
      sck_total++;
      last_period = $time - last_rise;
      last_rise = $time;
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        mon_vec++;
        if (exp_q.size() == 0) begin
          mon_bad++;
          $display("FAIL %s unexpected byte actual=%h expected=none", cur_req, nb);
        end else begin
          logic [7:0] eb;
          eb = exp_q.pop_front();
          if (nb !== eb) begin
            mon_bad++;
            $display("FAIL %s serial byte actual=%h expected=%h", cur_req, nb, eb);
          end
        end
      end
    end
  end
  always @(posedge spi_cs_n) if (!rst) cs_rise_total++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    drv_vec++;
    if (act !== exp) begin
      drv_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(4'h0, v);
      if (!v[16]) break;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int tx, input int rx, input int dv, input bit go);
    return {6'b0, 2'(dv), 5'b0, 2'b00, 1'b0, 7'b0, go, 4'(rx), 4'(tx)};
  endfunction

  task automatic push_stream(input logic [31:0] cmd, input logic [31:0] dat, input int tx, input int rx);
    for (int i = 0; i < tx; i++) begin
      if (i == 0)      exp_q.push_back(cmd[7:0]);
      else if (i < 4)  exp_q.push_back(cmd[8*(4-i) +: 8]);
      else             exp_q.push_back(dat[8*(i-4) +: 8]);
    end
    for (int i = 0; i < rx; i++) exp_q.push_back(8'h00);
  endtask

  // full transfer with checks of stream, framing, clock rate and data word
  task automatic xfer(input string req, input logic [31:0] cmd, input logic [31:0] dat,
                      input int tx, input int rx, input int dv, input logic [31:0] rsp);
    int s0, c0;
    logic [31:0] v, exp_d;
    cur_req = req;
    wr(4'h4, cmd);
    wr(4'h8, dat);
    resp = rsp; mtx_bits = 8 * tx;
    push_stream(cmd, dat, tx, rx);
    s0 = sck_total; c0 = cs_rise_total;
    wr(4'h0, ctrl_word(tx, rx, dv, 1'b1));
    wait_idle();
    check({req, " R3 queue drained"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    check("R6 clock pulse count", 32'(sck_total - s0), 32'(8 * (tx + rx)));
    check("R6 single select window", 32'(cs_rise_total - c0), 32'd1);
    check("R10 clock period", 32'(last_period), 32'(2 * (1 << dv) * CLK_PERIOD));
    exp_d = dat;
    if (rx > 0) begin
      exp_d = '0;
      for (int i = 0; i < rx; i++) exp_d[8*i +: 8] = rsp[31-8*i -: 8];
    end
    rd(4'h8, v);
    check("R4 data word after transfer", v, exp_d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", drv_vec + mon_vec + 1, drv_bad + mon_bad + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0, c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'h0, v); check("R1 control", v, 32'h0);
    rd(4'h4, v); check("R1 command", v, 32'h0);
    rd(4'h8, v); check("R1 data", v, 32'h0);
    check("R1 select high", 32'(spi_cs_n), 32'd1);
    check("R1 clock low", 32'(spi_sck), 32'd0);
    // R2 register readback, start bit reads zero
    wr(4'h0, 32'h0306_0053);
    rd(4'h0, v); check("R2 control fields", v, 32'h0306_0053);
    wr(4'h4, 32'h1234_56AB);
    rd(4'h4, v); check("R2 command register", v, 32'h1234_56AB);
    wr(4'h8, 32'h0BAD_F00D);
    rd(4'h8, v); check("R2 data register", v, 32'h0BAD_F00D);
    // R3/R4 program-like stream, no receive: data kept
    xfer("R3", 32'hABCDEF02, 32'h44332211, 6, 0, 0, 32'h0);
    // R4 one receive byte after four transmit bytes
    xfer("R4", 32'h000000AB, 32'h0, 4, 1, 0, 32'h17000000);
    // R4 four receive bytes, divider 2
    xfer("R4", 32'h00000005, 32'h0, 1, 4, 2, 32'hDEADBEEF);
    // R10 divider 3, two receive bytes, all eight transmit bytes
    xfer("R10", 32'h00112233, 32'h8899AABB, 8, 2, 3, 32'h5AC30000);
    // R7/R8 writes while busy
    cur_req = "R8";
    wr(4'h4, 32'h000000AA);
    mtx_bits = 32; resp = '0;
    push_stream(32'h000000AA, 32'h0, 4, 0);
    s0 = sck_total;
    wr(4'h0, ctrl_word(4, 0, 1, 1'b1));
    rd(4'h0, v); check("R7 busy during transfer", 32'(v[16]), 32'd1);
    wr(4'h4, 32'h5555_5555);
    wr(4'h0, ctrl_word(1, 0, 0, 1'b1));
    wait_idle();
    rd(4'h0, v); check("R7 busy cleared", 32'(v[16]), 32'd0);
    check("R8 control unchanged", v, 32'h0100_0004);
    rd(4'h4, v); check("R8 command unchanged", v, 32'h0000_00AA);
    check("R8 no second transfer", 32'(sck_total - s0), 32'd32);
    check("R8 queue drained", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    // R9 zero transmit count
    cur_req = "R9";
    wr(4'h8, 32'hCAFE_F00D);
    s0 = sck_total; c0 = cs_rise_total;
    wr(4'h0, ctrl_word(0, 2, 0, 1'b1));
    rd(4'h0, v); check("R9 busy never set", 32'(v[16]), 32'd0);
    repeat (40) @(negedge clk);
    check("R9 select stayed high", 32'(cs_rise_total - c0), 32'd0);
    check("R9 no clock pulses", 32'(sck_total - s0), 32'd0);
    rd(4'h8, v); check("R9 data unchanged", v, 32'hCAFE_F00D);
    $display("== %0d vectors applied, %0d miscompares ==", drv_vec + mon_vec, drv_bad + mon_bad);
    $finish;
  end
endmodule